// File: doc/BRIEF.md
# Vector Immediate Right-Shift Unit

This block takes one vector operation per beat and shifts every element of the source vector right by an amount carried in a packed immediate. The same immediate also selects the element width. Each element can optionally be rounded to nearest, with halves rounded upward. Each element can also be added into the matching element of a prior destination vector. Elements are 8, 16, 32 or 64 bits wide. A width select chooses between a full 128-bit vector and a 64-bit vector. In the 64-bit case the upper half of the result is driven to zero.

Operations enter on a valid/ready input stream and leave on a valid/ready output stream, through a single registered stage. Input and output use these rules:
- The input is accepted on any clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the result and both flags hold steady and no new input is accepted.

Two immediate encodings are illegal, and each one still produces an output beat:
- An empty width field raises a decode-error flag.
- A 64-bit element width combined with the 64-bit vector width raises a reserved-encoding flag.
In both cases the result vector is all zeros.

Top module: `vshr_imm_unit`

## Requirements
- R1: When `imm_hi` is 0000, the output beat has `dec_err`=1, `rsv_err`=0 and `res_vec`=0.
- R2: When `imm_hi[3]`=1 and `wide`=0, the output beat has `rsv_err`=1, `dec_err`=0 and `res_vec`=0. The two flags are never high together.
- R3: The element width is 8 shifted left by the index of the highest set bit of `imm_hi` (bit0→8, bit1→16, bit2→32, bit3→64). The shift amount is 2×width minus the 7-bit value {`imm_hi`,`imm_lo`}, which gives a range of 1 to width. Elements are packed with element 0 in the least significant bits.
- R4: With `sgn`=1 each element is shifted arithmetically; with `sgn`=0 it is shifted logically. A shift equal to the width gives all sign bits or zero.
- R5: With `rnd`=1, bit (shift−1) of the original element is added to the shifted element. At a full-width shift this is the element's top bit.
- R6: With `acc`=1, the shifted and possibly rounded element is added modulo 2^width to the matching element of `dst_vec`.
- R7: `wide`=1 processes all 128 bits. `wide`=0 processes the low 64 bits and drives `res_vec[127:64]` to zero.
- R8: `in_ready` = !`out_valid` || `out_ready`. A beat accepted at an edge appears on the outputs after that edge. A stalled output holds stable.
- R9: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can accept a beat |
| wide | input | 1 | 1: 128-bit vector, 0: 64-bit vector |
| imm_hi | input | 4 | Upper immediate field (width and shift) |
| imm_lo | input | 3 | Lower immediate field (shift) |
| sgn | input | 1 | 1: arithmetic shift, 0: logical |
| rnd | input | 1 | Enable rounding correction |
| acc | input | 1 | Enable accumulation into destination |
| src_vec | input | 128 | Source vector |
| dst_vec | input | 128 | Prior destination vector |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer accepts result |
| res_vec | output | 128 | Result vector |
| dec_err | output | 1 | Invalid encoding (empty width field) |
| rsv_err | output | 1 | Reserved encoding (64-bit elements on 64-bit vector) |

## Verification
The assertions check the following on every cycle:
- the flags are mutually exclusive;
- a flagged beat carries a zero result;
- the upper half is zero after a narrow operation;
- each illegal encoding raises its own flag on the following beat;
- a stalled output holds.

Only the bench's sweeps can show the arithmetic in each lane. This covers the width and shift decode, the arithmetic against logical fill, the rounding increment including the full-width shift, and the modular accumulation. The sweeps compare against a reference built on floor division.

// File: rtl/vshr_pkg.sv
package vshr_pkg;
  localparam int unsigned NSIZES   = 4;
  localparam int unsigned LANE_MIN = 8;
  localparam int unsigned SH_W     = 7;

  typedef struct packed {
    logic [1:0]      size_idx;
    logic [SH_W-1:0] sh;
    logic            dec_err;
    logic            rsv_err;
  } vshr_dec_t;
endpackage

// File: rtl/vshr_decode.sv
module vshr_decode
  import vshr_pkg::*;
(
  input  logic      wide,
  input  logic [3:0] imm_hi,
  input  logic [2:0] imm_lo,
  output vshr_dec_t dec
);
  logic [7:0] twice;
  logic [7:0] sh_full;

  always_comb begin
    dec = '0;
    casez (imm_hi)
      4'b1???: dec.size_idx = 2'd3;
      4'b01??: dec.size_idx = 2'd2;
      4'b001?: dec.size_idx = 2'd1;
      default: dec.size_idx = 2'd0;
    endcase
    twice   = 8'd16 << dec.size_idx;
    sh_full = twice - {1'b0, imm_hi, imm_lo};
    dec.sh  = sh_full[SH_W-1:0];
    dec.dec_err = (imm_hi == 4'b0000);
    dec.rsv_err = imm_hi[3] & ~wide;
    if (dec.dec_err) dec.sh = 7'd1;
  end
endmodule

// File: rtl/vshr_lane.sv
module vshr_lane
  import vshr_pkg::*;
#(
  parameter int unsigned LW = 8
) (
  input  logic [LW-1:0]   x,
  input  logic [LW-1:0]   d,
  input  logic [SH_W-1:0] sh,
  input  logic            sgn,
  input  logic            rnd,
  input  logic            acc,
  output logic [LW-1:0]   y
);
  logic [2*LW-1:0] ext;
  logic [2*LW-1:0] shf;
  logic [2*LW-1:0] pre;
  logic            rbit;

  always_comb begin
    ext  = {{LW{sgn & x[LW-1]}}, x};
    shf  = ext >> sh;
    pre  = ext >> (sh - 7'd1);
    rbit = rnd & pre[0];
    y    = shf[LW-1:0] + LW'(rbit) + (acc ? d : '0);
  end
endmodule

// File: rtl/vshr_lane_group.sv
module vshr_lane_group
  import vshr_pkg::*;
#(
  parameter int unsigned VW = 128,
  parameter int unsigned LW = 8
) (
  input  logic [VW-1:0]   src,
  input  logic [VW-1:0]   dst,
  input  logic [SH_W-1:0] sh,
  input  logic            sgn,
  input  logic            rnd,
  input  logic            acc,
  output logic [VW-1:0]   res
);
  localparam int unsigned NL = VW / LW;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    vshr_lane #(.LW(LW)) u_lane (
      .x  (src[i*LW +: LW]),
      .d  (dst[i*LW +: LW]),
      .sh (sh),
      .sgn(sgn),
      .rnd(rnd),
      .acc(acc),
      .y  (res[i*LW +: LW])
    );
  end
endmodule

// File: rtl/vshr_imm_unit.sv
module vshr_imm_unit
  import vshr_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             wide,
  input  logic [3:0]       imm_hi,
  input  logic [2:0]       imm_lo,
  input  logic             sgn,
  input  logic             rnd,
  input  logic             acc,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] dst_vec,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] res_vec,
  output logic             dec_err,
  output logic             rsv_err
);
  localparam int unsigned HALF_W = VEC_W / 2;

  vshr_dec_t        dec;
  logic [VEC_W-1:0] grp_res [NSIZES];
  logic [VEC_W-1:0] nxt_res;
  logic             fire;

  vshr_decode u_dec (
    .wide  (wide),
    .imm_hi(imm_hi),
    .imm_lo(imm_lo),
    .dec   (dec)
  );

  for (genvar s = 0; s < NSIZES; s++) begin : g_size
    vshr_lane_group #(.VW(VEC_W), .LW(LANE_MIN << s)) u_grp (
      .src(src_vec),
      .dst(dst_vec),
      .sh (dec.sh),
      .sgn(sgn),
      .rnd(rnd),
      .acc(acc),
      .res(grp_res[s])
    );
  end

  always_comb begin
    nxt_res = grp_res[dec.size_idx];
    if (!wide) nxt_res[VEC_W-1:HALF_W] = '0;
    if (dec.dec_err || dec.rsv_err) nxt_res = '0;
  end

  assign in_ready = ~out_valid | out_ready;
  assign fire     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_vec   <= '0;
      dec_err   <= 1'b0;
      rsv_err   <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      res_vec   <= nxt_res;
      dec_err   <= dec.dec_err;
      rsv_err   <= dec.rsv_err & ~dec.dec_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vshr_imm_chk.sv
module vshr_imm_chk #(
  parameter int unsigned VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             wide,
  input logic [3:0]       imm_hi,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] res_vec,
  input logic             dec_err,
  input logic             rsv_err
);
  localparam int unsigned HALF_W = VEC_W / 2;
  logic last_wide;

  always_ff @(posedge clk) begin
    if (!rst_n) last_wide <= 1'b1;
    else if (in_valid && in_ready) last_wide <= wide;
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_err && rsv_err)); // R2
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (dec_err || rsv_err) |-> res_vec == '0); // R1
  AST_DEC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && imm_hi == 4'b0000 |=> out_valid && dec_err); // R1
  AST_RSV_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && imm_hi[3] && !wide |=> out_valid && rsv_err); // R2
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !last_wide |-> res_vec[VEC_W-1:HALF_W] == '0); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_vec) && $stable(dec_err)); // R8
  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready)); // R8
endmodule

bind vshr_imm_unit vshr_imm_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .wide(wide), .imm_hi(imm_hi), .out_valid(out_valid), .out_ready(out_ready),
  .res_vec(res_vec), .dec_err(dec_err), .rsv_err(rsv_err)
);

// File: tb/tb_vshr_imm_unit.sv
`timescale 1ns/1ps
module tb_vshr_imm_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         wide = 1'b0;
  logic [3:0]   imm_hi = '0;
  logic [2:0]   imm_lo = '0;
  logic         sgn = 1'b0, rnd = 1'b0, acc = 1'b0;
  logic [127:0] src_vec = '0, dst_vec = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] res_vec;
  logic         dec_err, rsv_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vshr_imm_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .wide(wide), .imm_hi(imm_hi), .imm_lo(imm_lo), .sgn(sgn), .rnd(rnd), .acc(acc),
    .src_vec(src_vec), .dst_vec(dst_vec), .out_valid(out_valid), .out_ready(out_ready),
    .res_vec(res_vec), .dec_err(dec_err), .rsv_err(rsv_err)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: floor division of the (sign- or zero-extended) element
  task automatic ref_model(input logic q, input logic [3:0] ih, input logic [2:0] il,
                           input logic sg, input logic rn, input logic ac,
                           input logic [127:0] src, input logic [127:0] dst,
                           output logic [127:0] res, output logic de, output logic re);
    int es, sh, nl;
    logic [127:0] x, dx, msk;
    logic signed [129:0] v, pe, ps, ph, num, qq, dd, r, rr;
    res = '0;
    de  = (ih == 4'd0);
    re  = !de && ih[3] && !q;
    if (de || re) return;
    es = 8;
    for (int k = 0; k < 4; k++) if (ih[k]) es = 8 << k;
    sh = 2 * es - (int'(ih) * 8 + int'(il));
    nl = (q ? 128 : 64) / es;
    msk = (128'd1 << es) - 128'd1;
    pe = 1; pe = pe <<< es;
    ps = 1; ps = ps <<< sh;
    ph = ps >>> 1;
    for (int i = 0; i < nl; i++) begin
      x  = (src >> (i * es)) & msk;
      dx = (dst >> (i * es)) & msk;
      v  = $signed({2'b00, x});
      if (sg && x[es-1]) v = v - pe;
      if (rn) num = v + ph; else num = v;
      qq = num / ps;
      if (num < 0 && (num % ps) != 0) qq = qq - 1;
      dd = $signed({2'b00, dx});
      if (ac) r = qq + dd; else r = qq;
      rr = r & (pe - 1);
      res = res | (rr[127:0] << (i * es));
    end
  endtask

  function automatic string tag_of(input logic q, input logic [3:0] ih,
                                   input logic sg, input logic rn, input logic ac);
    if (ih == 4'd0) return "R1";
    if (ih[3] && !q) return "R2";
    if (ac) return "R6";
    if (rn) return "R5";
    if (!q) return "R7";
    if (sg) return "R4";
    return "R3";
  endfunction

  task automatic drive(input logic q, input logic [3:0] ih, input logic [2:0] il,
                       input logic sg, input logic rn, input logic ac,
                       input logic [127:0] s, input logic [127:0] d);
    wide = q; imm_hi = ih; imm_lo = il; sgn = sg; rnd = rn; acc = ac;
    src_vec = s; dst_vec = d; in_valid = 1'b1;
  endtask

  task automatic run_one(input logic q, input logic [3:0] ih, input logic [2:0] il,
                         input logic sg, input logic rn, input logic ac,
                         input logic [127:0] s, input logic [127:0] d);
    logic [127:0] er;
    logic ed, erv;
    string t;
    ref_model(q, ih, il, sg, rn, ac, s, d, er, ed, erv);
    t = tag_of(q, ih, sg, rn, ac);
    @(negedge clk);
    drive(q, ih, il, sg, rn, ac, s, d);
    @(negedge clk);
    in_valid = 1'b0;
    check({t, " result"}, res_vec, er);
    check({t, " flags"}, {125'd0, out_valid, dec_err, rsv_err}, {125'd0, 1'b1, ed, erv});
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] ea, eb;
    logic d0, d1;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset", {126'd0, out_valid, in_ready}, {126'd0, 1'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);

    // Directed full-width-shift corners (R4, R5)
    run_one(1, 4'b0001, 3'd0, 1, 0, 0, {16{8'h80}}, '0);       // R4 sign fill -> FF
    run_one(1, 4'b0001, 3'd0, 1, 1, 0, {16{8'h80}}, '0);       // R5 -1 + top bit -> 00
    run_one(1, 4'b1000, 3'd0, 0, 1, 0, {2{64'h8000_0000_0000_0001}}, '0); // R5 logical full shift + round -> 1

    // Exhaustive sweep of all encodings and modes
    for (int q = 0; q < 2; q++)
      for (int ih = 0; ih < 16; ih++)
        for (int il = 0; il < 8; il++)
          for (int m = 0; m < 8; m++) begin
            run_one(q[0], ih[3:0], il[2:0], m[0], m[1], m[2], rnd128(), rnd128());
            run_one(q[0], ih[3:0], il[2:0], m[0], m[1], m[2],
                    {8{16'h807F}}, {8{16'hFF01}});
          end

    // R8: back-pressure
    ref_model(1, 4'b0010, 3'd3, 1, 1, 1, {8{16'hC3A5}}, {8{16'h1111}}, ea, d0, d1);
    ref_model(1, 4'b0100, 3'd7, 0, 0, 0, {4{32'hDEAD_BEEF}}, '0, eb, d0, d1);
    @(negedge clk);
    out_ready = 1'b0;
    drive(1, 4'b0010, 3'd3, 1, 1, 1, {8{16'hC3A5}}, {8{16'h1111}});
    @(negedge clk);
    check("R8 first beat", res_vec, ea);
    drive(1, 4'b0100, 3'd7, 0, 0, 0, {4{32'hDEAD_BEEF}}, '0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 stall ready low", {127'd0, in_ready}, 128'd0);
      check("R8 stall hold", res_vec, ea);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 second beat", res_vec, eb);
    @(negedge clk);
    check("R8 drain", {127'd0, out_valid}, 128'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule